// File: doc/BRIEF.md
# x86-style arithmetic flag evaluator

This unit computes the six legacy x86 status flags for one arithmetic operation and writes them into its own flag register. The flags are carry (CF), auxiliary carry (AF), overflow (OF), parity (PF), zero (ZF) and sign (SF). Each operation has two 64-bit operands, an operation code and an operand-width code. The arithmetic result is used only to derive the flags and is then discarded. The carry flag held in the register is the carry or borrow input for add-with-carry and subtract-with-borrow.

Issue follows a valid/ready handshake. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. The unit then drops `in_ready` for exactly one cycle. An offer made in that cycle is not taken, and the caller must hold it until `in_ready` rises again. Accepted operations therefore arrive at most once every two cycles. The flag register is written two cycles after the issue cycle, and `flags_upd` pulses in the cycle the new value becomes visible.

Top module: `arith_flag_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `flags_o` is 0, `flags_upd` is 0 and `in_ready` is 1.
- R2: An offer is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the one cycle that follows an acceptance. An offer made while `in_ready` is low is ignored and changes no flag.
- R3: The flags of an operation issued in cycle T are visible on `flags_o` in cycle T+2, and `flags_upd` is high in that cycle only. Without an update, `flags_o` holds its value. Bit layout: [0] CF, [1] PF, [2] AF, [3] ZF, [4] SF, [5] OF.
- R4: Width code 0/1/2/3 selects 8/16/32/64 bits. Operand bits above the selected width have no effect on any flag.
- R5: For add (code 0) and add-with-carry (code 1, which also adds the stored CF), CF is the carry out of the selected width. OF is set when both operands have the same sign and the result's sign differs from it.
- R6: For subtract (code 2), CF is set when lhs < rhs as unsigned values. For subtract-with-borrow (code 3), CF is set when lhs < rhs + stored CF. OF is set when the operands have different signs and the result's sign differs from lhs.
- R7: AF is bit 4 of lhs XOR rhs XOR result. The exception is subtract-with-borrow, where AF is set exactly when lhs[3:0] < rhs[3:0], whatever the incoming borrow.
- R8: At each width, OF reports signed overflow for the add and subtract forms (for example 0x7F + 0x01 at 8 bits gives OF=1, SF=1).
- R9: Increment (code 4) and decrement (code 5) use 1 as the second operand and leave CF unchanged. Increment sets OF only when the input equals the signed maximum of the width. Decrement sets OF only when the input equals the signed minimum.
- R10: Unsigned add (code 6) and unsigned subtract (code 7) force OF to 0 at every width. Every other flag is computed as for codes 0 and 2.
- R11: PF is 1 when the low 8 bits of the result hold an even number of ones, at every width. ZF is 1 when the truncated result is zero. SF is the result's top bit at the selected width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 inc, 5 dec, 6 unsigned add, 7 unsigned sub) |
| in_width | input | 2 | Width code (0:8, 1:16, 2:32, 3:64 bits) |
| in_lhs | input | 64 | First operand |
| in_rhs | input | 64 | Second operand (ignored for inc and dec) |
| flags_o | output | 6 | Flag register {OF,SF,ZF,AF,PF,CF} |
| flags_upd | output | 1 | High for one cycle when the flag register was just written |

## Verification
The bench builds the unit with its default parameter, a 64-bit datapath with four width lanes. This makes every operation × width pair reachable, including carry and borrow out of bit 63, which a narrower build cannot produce. The same build lets the bench test truncation with non-zero upper operand bits at each narrower lane. The bench's reference model tracks CF across issues, so add-with-carry and subtract-with-borrow run with both carry-in values.

// File: rtl/afe_pkg.sv
package afe_pkg;
  localparam int AFE_NUM_WIDTHS = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_ADDU = 3'd6,
    OP_SUBU = 3'd7
  } afe_op_e;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } afe_wid_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } afe_flags_t;
endpackage

// File: rtl/afe_width_dec.sv
module afe_width_dec
  import afe_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_W  = AFE_NUM_WIDTHS
) (
  input  afe_wid_e             wid,
  output logic [DATA_W-1:0]    mask_o,
  output logic [DATA_W-1:0]    top_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] lane_mask [NUM_W];
  logic [DATA_W-1:0] lane_top  [NUM_W];

  // Lane i covers DATA_W >> (NUM_W-1-i) bits: the widest lane is the full datapath.
  for (genvar i = 0; i < NUM_W; i++) begin : g_lane
    localparam int LW = DATA_W >> (NUM_W - 1 - i);
    if (LW == DATA_W) begin : g_full
      assign lane_mask[i] = '1;
    end else begin : g_part
      assign lane_mask[i] = (ONE << LW) - ONE;
    end
    assign lane_top[i] = ONE << (LW - 1);
  end

  assign mask_o = lane_mask[wid];
  assign top_o  = lane_top[wid];
endmodule

// File: rtl/afe_flag_calc.sv
module afe_flag_calc
  import afe_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  afe_op_e           op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] top,
  input  logic              cf_in,
  output afe_flags_t        flags
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              is_sub, is_step, is_uns, cin;
  logic [DATA_W-1:0] opnd_b, res, xsum, ovec;
  logic [DATA_W:0]   wide;

  always_comb begin
    is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC) || (op == OP_SUBU);
    is_step = (op == OP_INC) || (op == OP_DEC);
    is_uns  = (op == OP_ADDU) || (op == OP_SUBU);
    cin     = ((op == OP_ADC) || (op == OP_SBB)) ? cf_in : 1'b0;
    opnd_b  = is_step ? ONE : rhs;

    // One guard bit above the datapath: narrower widths keep their carry in the masked-off
    // region, the full width keeps it in the guard bit; a borrow always wraps into the guard bit.
    if (is_sub) wide = {1'b0, lhs} - {1'b0, opnd_b} - {{DATA_W{1'b0}}, cin};
    else        wide = {1'b0, lhs} + {1'b0, opnd_b} + {{DATA_W{1'b0}}, cin};

    res  = wide[DATA_W-1:0] & mask;
    xsum = lhs ^ opnd_b ^ res;
    ovec = is_sub ? ((lhs ^ opnd_b) & (lhs ^ res)) : (~(lhs ^ opnd_b) & (lhs ^ res));

    if (is_step)     flags.cf_f = cf_in;
    else if (is_sub) flags.cf_f = wide[DATA_W];
    else             flags.cf_f = |(wide & ~{1'b0, mask});

    flags.af_f = (op == OP_SBB) ? (lhs[3:0] < rhs[3:0]) : xsum[4];
    flags.of_f = is_uns ? 1'b0 : |(ovec & top);
    flags.pf_f = ~^res[7:0];
    flags.zf_f = ~|res;
    flags.sf_f = |(res & top);
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afe_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_width,
  input  logic [DATA_W-1:0] in_lhs,
  input  logic [DATA_W-1:0] in_rhs,
  output logic [5:0]        flags_o,
  output logic              flags_upd
);
  logic              accept;
  logic [DATA_W-1:0] w_mask, w_top;

  logic              s1_vld;
  afe_op_e           s1_op;
  logic [DATA_W-1:0] s1_lhs, s1_rhs, s1_mask, s1_top;

  afe_flags_t        calc_flags, flag_q;
  logic              upd_q;

  assign in_ready = ~s1_vld;
  assign accept   = in_valid & in_ready;

  afe_width_dec #(.DATA_W(DATA_W)) u_wdec (
    .wid    (afe_wid_e'(in_width)),
    .mask_o (w_mask),
    .top_o  (w_top)
  );

  // Stage 1: capture truncated operands and width decode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_op   <= OP_ADD;
      s1_lhs  <= '0;
      s1_rhs  <= '0;
      s1_mask <= '0;
      s1_top  <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_op   <= afe_op_e'(in_op);
        s1_lhs  <= in_lhs & w_mask;
        s1_rhs  <= in_rhs & w_mask;
        s1_mask <= w_mask;
        s1_top  <= w_top;
      end
    end
  end

  afe_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op    (s1_op),
    .lhs   (s1_lhs),
    .rhs   (s1_rhs),
    .mask  (s1_mask),
    .top   (s1_top),
    .cf_in (flag_q.cf_f),
    .flags (calc_flags)
  );

  // Stage 2: flag register write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= s1_vld;
      if (s1_vld) flag_q <= calc_flags;
    end
  end

  assign flags_o   = {flag_q.of_f, flag_q.sf_f, flag_q.zf_f, flag_q.af_f, flag_q.pf_f, flag_q.cf_f};
  assign flags_upd = upd_q;
endmodule

// File: rtl/afe_chk.sv
module afe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_op,
  input logic [5:0] flags_o,
  input logic       flags_upd
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_update_two_after: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 flags_upd);

  a_r3_update_has_issue: assert property (@(posedge clk) disable iff (!rst_n)
    flags_upd |-> $past(in_valid && in_ready, 2));

  a_r3_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_upd |-> $stable(flags_o));

  a_r9_cf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == 3'd4 || in_op == 3'd5)) |-> ##2 (flags_o[0] == $past(flags_o[0], 2)));

  a_r10_of_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == 3'd6 || in_op == 3'd7)) |-> ##2 !flags_o[5]);

  a_r11_zero_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_upd && flags_o[3]) |-> (flags_o[1] && !flags_o[4]));
endmodule

bind arith_flag_unit afe_chk u_afe_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .flags_o   (flags_o),
  .flags_upd (flags_upd)
);

// File: tb/tb_arith_flag_unit.sv
`timescale 1ns/1ps
module tb_arith_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_width = '0;
  logic [63:0] in_lhs = '0;
  logic [63:0] in_rhs = '0;
  logic [5:0]  flags_o;
  logic        flags_upd;

  int checks = 0;
  int errors = 0;
  logic [5:0] model_flags = '0;

  always #5 clk = ~clk;

  arith_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_width(in_width), .in_lhs(in_lhs), .in_rhs(in_rhs),
    .flags_o(flags_o), .flags_upd(flags_upd)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: {OF,SF,ZF,AF,PF,CF}.
  function automatic logic [5:0] ref_flags(input int op, input int w, input logic [63:0] a,
                                           input logic [63:0] b, input logic cf);
    int n = 8 << w;
    logic [63:0] mask = (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
    logic [63:0] top = 64'd1 << (n - 1);
    logic [63:0] l = a & mask;
    logic [63:0] r = b & mask;
    logic [63:0] res;
    logic [64:0] wsum;
    logic c, cfo, afo, ofo;
    c = (op == 1 || op == 3) ? cf : 1'b0;
    case (op)
      0, 1, 6: begin
        wsum = {1'b0, l} + {1'b0, r} + {64'd0, c};
        res = wsum[63:0] & mask;
        cfo = wsum > {1'b0, mask};
        afo = ((l ^ r ^ res) & 64'h10) != 0;
        ofo = (op == 6) ? 1'b0 : (((~(l ^ r)) & (l ^ res) & top) != 0);
      end
      2, 3, 7: begin
        wsum = {1'b0, r} + {64'd0, c};
        res = (l - r - {63'd0, c}) & mask;
        cfo = {1'b0, l} < wsum;
        afo = (op == 3) ? (l[3:0] < r[3:0]) : (((l ^ r ^ res) & 64'h10) != 0);
        ofo = (op == 7) ? 1'b0 : (((l ^ r) & (l ^ res) & top) != 0);
      end
      4: begin
        res = (l + 64'd1) & mask;
        cfo = cf;
        afo = ((l ^ 64'd1 ^ res) & 64'h10) != 0;
        ofo = (l == (mask >> 1));
      end
      default: begin
        res = (l - 64'd1) & mask;
        cfo = cf;
        afo = ((l ^ 64'd1 ^ res) & 64'h10) != 0;
        ofo = (l == top);
      end
    endcase
    return {ofo, (res & top) != 0, res == 0, afo, ~^res[7:0], cfo};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R5";
      2, 3: return "R6";
      4, 5: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Issue one operation and check handshake, timing and flags. Starts and ends at a negedge.
  task automatic issue(input int op, input int w, input logic [63:0] a, input logic [63:0] b,
                       input string req, output logic [5:0] got);
    logic [5:0] exp = ref_flags(op, w, a, b, model_flags[0]);
    chk(in_ready === 1'b1, "R2 ready before issue", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b1; in_op = 3'(op); in_width = 2'(w); in_lhs = a; in_rhs = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0, "R2 busy after accept", {63'd0, in_ready}, 64'd0);
    chk(flags_upd === 1'b0, "R3 no early update", {63'd0, flags_upd}, 64'd0);
    @(negedge clk);
    chk(flags_upd === 1'b1, "R3 update pulse", {63'd0, flags_upd}, 64'd1);
    chk(flags_o === exp, req, {58'd0, flags_o}, {58'd0, exp});
    model_flags = exp;
    got = flags_o;
  endtask

  task automatic t_reset();
    chk(flags_o === 6'd0, "R1 flags in reset", {58'd0, flags_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flags_o === 6'd0, "R1 flags after reset", {58'd0, flags_o}, 64'd0);
    chk(flags_upd === 1'b0, "R1 no update", {63'd0, flags_upd}, 64'd0);
    chk(in_ready === 1'b1, "R1 ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_all_combos();
    logic [63:0] pa [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210,
                            64'h8000_0000_8000_8080, 64'h7FFF_FFFF_7FFF_7F7F, 64'h0000_0000_0000_0010};
    logic [63:0] pb [6] = '{64'h0, 64'h1, 64'h0123_4567_89AB_CDEF,
                            64'h8000_0000_8000_8080, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0000_0000_0000_0011};
    logic [5:0] g;
    for (int op = 0; op < 8; op++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 6; p++)
          issue(op, w, pa[p], pb[p], tag_of(op), g);
  endtask

  task automatic t_truncation();
    logic [5:0] clean, dirty;
    issue(0, 0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0020, "R4 clean", clean);
    issue(0, 0, 64'hABCD_0000_1234_55F0, 64'h7777_FFFF_0000_1120, "R4 upper bits", dirty);
    chk(dirty === clean, "R4 upper bits ignored", {58'd0, dirty}, {58'd0, clean});
    issue(2, 1, 64'hFFFF_FFFF_0000_0005, 64'h1234_5678_0000_0005, "R4 sub16", dirty);
    chk(dirty === 6'b001010, "R4 zero at 16 bits", {58'd0, dirty}, 64'b001010);
  endtask

  task automatic t_carry_borrow();
    logic [5:0] g;
    issue(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R5 carry out of bit 63", g);
    chk(g[0] === 1'b1 && g[3] === 1'b1, "R5 CF ZF 64", {58'd0, g}, 64'h9);
    issue(1, 0, 64'h00, 64'h00, "R5 adc uses CF", g);
    chk(g[0] === 1'b0 && g[3] === 1'b0, "R5 adc result 1", {58'd0, g}, 64'h0);
    issue(2, 2, 64'h1, 64'h2, "R6 sub borrow", g);
    chk(g[0] === 1'b1 && g[4] === 1'b1, "R6 CF SF", {58'd0, g}, 64'h11);
    issue(3, 0, 64'h05, 64'h04, "R6 sbb with borrow", g);
    chk(g[0] === 1'b0 && g[3] === 1'b1, "R6 sbb zero", {58'd0, g}, 64'h8);
  endtask

  task automatic t_af_sbb();
    logic [5:0] g;
    issue(0, 0, 64'hFF, 64'h01, "R7 set CF", g);
    issue(3, 0, 64'h15, 64'h05, "R7 sbb af", g);
    chk(g[2] === 1'b0, "R7 borrow ignored for AF", {63'd0, g[2]}, 64'd0);
    issue(3, 0, 64'h10, 64'h0F, "R7 sbb nibble", g);
    chk(g[2] === 1'b1, "R7 nibble compare", {63'd0, g[2]}, 64'd1);
    issue(0, 0, 64'h0F, 64'h01, "R7 add af", g);
    chk(g[2] === 1'b1, "R7 add AF", {63'd0, g[2]}, 64'd1);
  endtask

  task automatic t_overflow();
    logic [5:0] g;
    issue(0, 0, 64'h7F, 64'h01, "R8 add ovf 8", g);
    chk(g[5] === 1'b1 && g[4] === 1'b1, "R8 OF SF", {58'd0, g}, 64'h30);
    issue(2, 2, 64'h8000_0000, 64'h1, "R8 sub ovf 32", g);
    chk(g[5] === 1'b1 && g[4] === 1'b0, "R8 sub OF", {58'd0, g}, 64'h20);
  endtask

  task automatic t_step();
    logic [5:0] g;
    issue(0, 0, 64'hFF, 64'h01, "R9 set CF", g);
    issue(4, 1, 64'h7FFF, 64'h0, "R9 inc max", g);
    chk(g[5] === 1'b1 && g[0] === 1'b1, "R9 inc OF, CF kept 1", {58'd0, g}, 64'h21);
    issue(4, 1, 64'h7FFE, 64'h0, "R9 inc below max", g);
    chk(g[5] === 1'b0, "R9 inc no OF", {63'd0, g[5]}, 64'd0);
    issue(0, 0, 64'h01, 64'h01, "R9 clear CF", g);
    issue(5, 2, 64'h8000_0000, 64'h0, "R9 dec min", g);
    chk(g[5] === 1'b1 && g[0] === 1'b0, "R9 dec OF, CF kept 0", {58'd0, g}, 64'h20);
    issue(5, 0, 64'h00, 64'h0, "R9 dec wrap", g);
    chk(g[0] === 1'b0 && g[4] === 1'b1, "R9 dec wrap CF kept", {58'd0, g}, 64'h10);
  endtask

  task automatic t_unsigned();
    logic [5:0] g;
    issue(6, 2, 64'h7FFF_FFFF, 64'h1, "R10 addu", g);
    chk(g[5] === 1'b0 && g[4] === 1'b1, "R10 addu OF 0", {58'd0, g}, 64'h10);
    issue(7, 3, 64'h8000_0000_0000_0000, 64'h1, "R10 subu", g);
    chk(g[5] === 1'b0 && g[0] === 1'b0, "R10 subu OF 0", {58'd0, g}, 64'h0);
  endtask

  task automatic t_parity();
    logic [5:0] g;
    issue(0, 3, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, "R11 pf low byte", g);
    chk(g[1] === 1'b1 && g[3] === 1'b0 && g[4] === 1'b1, "R11 PF ZF SF", {58'd0, g}, 64'h12);
    issue(0, 1, 64'h0100, 64'h0001, "R11 odd", g);
    chk(g[1] === 1'b0, "R11 odd parity", {63'd0, g[1]}, 64'd0);
  endtask

  task automatic t_busy_reject();
    logic [5:0] exp_a = ref_flags(0, 0, 64'h7F, 64'h01, model_flags[0]);
    in_valid = 1'b1; in_op = 3'd0; in_width = 2'd0; in_lhs = 64'h7F; in_rhs = 64'h01;
    @(negedge clk);
    in_op = 3'd2; in_lhs = 64'h00; in_rhs = 64'h00;
    chk(in_ready === 1'b0, "R2 busy while offered", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(flags_o === exp_a, "R2 first op flags", {58'd0, flags_o}, {58'd0, exp_a});
    @(negedge clk);
    chk(flags_upd === 1'b0, "R2 rejected offer no update", {63'd0, flags_upd}, 64'd0);
    chk(flags_o === exp_a, "R2 rejected offer ignored", {58'd0, flags_o}, {58'd0, exp_a});
    model_flags = exp_a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_all_combos();
    t_truncation();
    t_carry_borrow();
    t_af_sbb();
    t_overflow();
    t_step();
    t_unsigned();
    t_parity();
    t_busy_reject();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule